// File: doc/BRIEF.md
# Lane-Rate PLL Divider Search Engine

This block works out the clock settings for one serial display lane. From a pixel clock, a lane count and a pixel format it derives the lane bit rate the link needs, with a 1.25x bandwidth margin. It then walks every allowed PLL input divider N. For each N it forms the even feedback multiplier M that puts the VCO nearest to that rate, and it keeps the candidate with the smallest distance. Last, it turns the chosen rate into an index in a table of frequency bands.

A request is a one-cycle `start` with the inputs valid in the same cycle. `busy` stays high for the whole computation. A one-cycle `done` marks the moment the result ports carry N, M, the rate reached, the band index and the error flag. The results then hold until the next request. All arithmetic runs through one shared multi-cycle restoring divider, one division at a time, and each N candidate takes two divisions.

Top module: `lane_pll_search`

## Requirements
- R1: Bits per pixel follow `pix_fmt`: 0 gives 24 (RGB888), 1 gives 24 (loosely packed RGB666), 2 gives 18 (packed RGB666), 3 gives 16 (RGB565).
- R2: The target rate in Hz is ((pclk_khz*1000) / lanes) * bpp / 8 * 10, each division truncated in that order. A target of 1,500,000,000 or more ends the request with `err` high, and no search is made.
- R3: The input dividers tried run from ceil(FREF_HZ/40 MHz) to floor(FREF_HZ/5 MHz), inclusive. A reported `n_div` lies in that window.
- R4: For each N, M is floor(target*N/FREF_HZ), raised by one when odd. A candidate is dropped if M is below 6 or above 512, so a reported `m_mult` is even and lies within 6..512.
- R5: The rate reached is floor(M*FREF_HZ/N). A candidate is dropped if that rate is below 80,000,000 or above 1,500,000,000.
- R6: The best distance starts at 1,500,000,000. A candidate replaces the best only when |target - rate| is strictly smaller, so on a tie the smaller N stays.
- R7: If no candidate survives, `err` is high on `done`.
- R8: `range_idx` is the first entry, scanning upward, of the band table whose upper limit in Mbps is at least ceil(rate/1,000,000). The first band ends at 89 Mbps and the last at 1500 Mbps.
- R9: `done` is high for exactly one cycle, with `busy` high. `busy` is low in the following cycle, and the result ports hold their values until the next accepted request.
- R10: A `start` that arrives while `busy` is high has no effect on the result that is computed.
- R11: After reset, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| pclk_khz | input | 20 | Pixel clock in kHz |
| lane_cnt | input | 3 | Number of lanes (1 or more) |
| pix_fmt | input | 2 | Pixel format code (see R1) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request failed (R2, R7) |
| n_div | output | NW | Chosen input divider |
| m_mult | output | 10 | Chosen feedback multiplier |
| lane_rate_hz | output | 32 | Lane rate reached, in Hz |
| range_idx | output | 6 | Frequency band index |

## Verification
Two things can meet in the same cycle: a new `start` and a computation that is still in progress. The same holds for the closing `done` strobe. The bench issues a second request with different inputs partway through a search, and another one exactly in the `done` cycle. It then judges the reported N, M, rate and band against the model result for the first request only. Random pixel clocks, lane counts and formats are mixed with directed cases on both sides of the 1500 Mbps limit and with rates too low to yield any legal M.

// File: rtl/lane_pll_pkg.sv
// Shared constants, types and helpers for the lane PLL divider search.
// Assumes rates are carried as unsigned integers in Hz.
package lane_pll_pkg;

    localparam int NBANDS = 39;
    localparam logic [31:0] RATE_CEIL_HZ = 32'd1_500_000_000;
    localparam logic [31:0] VCO_LOW_HZ   = 32'd80_000_000;

    // Upper limit in Mbps of each frequency band, ascending.
    localparam logic [10:0] BAND_TOP [NBANDS] = '{
        11'd89,   11'd99,   11'd109,  11'd129,  11'd139,  11'd149,
        11'd169,  11'd179,  11'd199,  11'd219,  11'd239,  11'd249,
        11'd269,  11'd299,  11'd329,  11'd359,  11'd399,  11'd449,
        11'd499,  11'd549,  11'd599,  11'd649,  11'd699,  11'd749,
        11'd799,  11'd849,  11'd899,  11'd949,  11'd999,  11'd1049,
        11'd1099, 11'd1149, 11'd1199, 11'd1249, 11'd1299, 11'd1349,
        11'd1399, 11'd1449, 11'd1500
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LANE,
        ST_MCAND,
        ST_FREQ,
        ST_NEXT,
        ST_MBPS,
        ST_FIN
    } srch_state_t;

    // Bits per pixel for a format code.
    function automatic logic [4:0] bpp_of(input logic [1:0] fmt);
        case (fmt)
            2'd0:    return 5'd24;
            2'd1:    return 5'd24;
            2'd2:    return 5'd18;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/lane_div_unit.sv
// Restoring unsigned divider, one quotient bit per cycle.
// A go pulse loads the operands, and done pulses W cycles later with the
// quotient valid. The quotient holds until the next go. Assumes go is not
// raised while a division runs.
module lane_div_unit #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    part;
    logic [W:0]    shifted;
    logic [W+1:0]  trial;
    logic [CW-1:0] cnt;
    logic          run;

    // Shift in the next dividend bit and try the subtraction.
    always_comb begin
        shifted = {part[W-1:0], quot[W-1]};
        trial   = {1'b0, shifted} - {2'b00, divisor};
    end

    // Iteration register: partial remainder, quotient and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part <= '0;
            quot <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                part <= '0;
                quot <= dividend;
                cnt  <= CW'(W);
                run  <= 1'b1;
            end else if (run) begin
                if (!trial[W+1]) begin
                    part <= trial[W:0];
                    quot <= {quot[W-2:0], 1'b1};
                end else begin
                    part <= shifted;
                    quot <= {quot[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lane_range_lut.sv
// Maps a rate in Mbps to the first band whose upper limit covers it.
// Assumes mbps does not exceed the last band limit. Above it, the last
// index is returned.
module lane_range_lut
    import lane_pll_pkg::*;
#(
    parameter int IW = 6
) (
    input  logic [10:0]   mbps,
    output logic [IW-1:0] idx
);
    // Priority scan from the top so the lowest matching band wins.
    always_comb begin
        idx = IW'(NBANDS - 1);
        for (int i = NBANDS - 1; i >= 0; i--) begin
            if (BAND_TOP[i] >= mbps) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lane_pll_search.sv
// Lane-rate PLL divider search: works out the target lane rate, scans the
// input dividers, keeps the even multiplier nearest the target, then
// looks up the band index. Uses one shared divider, so each N costs two
// divisions. Assumes lane_cnt >= 1 and FREF_HZ >= 5 MHz.
module lane_pll_search
    import lane_pll_pkg::*;
#(
    parameter int FREF_HZ = 24_000_000,
    parameter int DW      = 40,
    parameter int NMIN    = (FREF_HZ + 39_999_999) / 40_000_000,
    parameter int NMAX    = FREF_HZ / 5_000_000,
    parameter int NW      = $clog2(NMAX + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [19:0]   pclk_khz,
    input  logic [2:0]    lane_cnt,
    input  logic [1:0]    pix_fmt,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [NW-1:0] n_div,
    output logic [9:0]    m_mult,
    output logic [31:0]   lane_rate_hz,
    output logic [5:0]    range_idx
);
    localparam int          TW      = DW + 8;
    localparam logic [DW-1:0] FREF_D = DW'(FREF_HZ);
    localparam logic [DW-1:0] MEG_D  = DW'(1_000_000);
    localparam logic [DW-1:0] CEIL_D = DW'(RATE_CEIL_HZ);
    localparam logic [DW-1:0] LOW_D  = DW'(VCO_LOW_HZ);

    srch_state_t   state;
    logic          div_go;
    logic [DW-1:0] div_a;
    logic [DW-1:0] div_b;
    logic          div_done;
    logic [DW-1:0] div_q;

    logic [1:0]    fmt_q;
    logic [DW-1:0] tgt;
    logic [NW-1:0] cur_n;
    logic [9:0]    cur_m;
    logic [DW-1:0] best_delta;
    logic [NW-1:0] best_n;
    logic [9:0]    best_m;
    logic [31:0]   best_f;
    logic          found;

    logic [TW-1:0] tgt_c;
    logic [DW-1:0] m_c;
    logic          m_ok;
    logic          f_ok;
    logic [DW-1:0] delta_c;
    logic [10:0]   mbps_c;
    logic [5:0]    idx_c;
    logic [NW-1:0] n_inc;

    lane_div_unit #(.W(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quot     (div_q)
    );

    lane_range_lut #(.IW(6)) u_lut (
        .mbps (mbps_c),
        .idx  (idx_c)
    );

    // Datapath helpers that act on the quotient of the current division.
    always_comb begin
        tgt_c   = (({{(TW-DW){1'b0}}, div_q} * TW'(bpp_of(fmt_q))) >> 3) * TW'(10);
        m_c     = div_q + DW'(div_q[0]);
        m_ok    = (m_c >= DW'(6)) && (m_c <= DW'(512));
        f_ok    = (div_q >= LOW_D) && (div_q <= CEIL_D);
        delta_c = (tgt >= div_q) ? (tgt - div_q) : (div_q - tgt);
        mbps_c  = (|div_q[DW-1:11]) ? 11'h7ff : div_q[10:0];
        n_inc   = cur_n + 1'b1;
    end

    // Status outputs decoded from the sequencer state.
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_FIN);
    end

    // Sequencer: target rate, divider scan, band lookup, result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            div_go       <= 1'b0;
            div_a        <= '0;
            div_b        <= '0;
            fmt_q        <= '0;
            tgt          <= '0;
            cur_n        <= '0;
            cur_m        <= '0;
            best_delta   <= '0;
            best_n       <= '0;
            best_m       <= '0;
            best_f       <= '0;
            found        <= 1'b0;
            err          <= 1'b0;
            n_div        <= '0;
            m_mult       <= '0;
            lane_rate_hz <= '0;
            range_idx    <= '0;
        end else begin
            div_go <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        div_a  <= DW'(pclk_khz) * DW'(1000);
                        div_b  <= DW'(lane_cnt);
                        fmt_q  <= pix_fmt;
                        div_go <= 1'b1;
                        state  <= ST_LANE;
                    end
                end
                ST_LANE: begin
                    if (div_done) begin
                        if (tgt_c >= TW'(RATE_CEIL_HZ)) begin
                            err          <= 1'b1;
                            n_div        <= '0;
                            m_mult       <= '0;
                            lane_rate_hz <= '0;
                            range_idx    <= '0;
                            state        <= ST_FIN;
                        end else begin
                            tgt        <= tgt_c[DW-1:0];
                            cur_n      <= NW'(NMIN);
                            best_delta <= CEIL_D;
                            found      <= 1'b0;
                            div_a      <= tgt_c[DW-1:0] * DW'(NMIN);
                            div_b      <= FREF_D;
                            div_go     <= 1'b1;
                            state      <= ST_MCAND;
                        end
                    end
                end
                ST_MCAND: begin
                    if (div_done) begin
                        if (m_ok) begin
                            cur_m  <= m_c[9:0];
                            div_a  <= m_c * FREF_D;
                            div_b  <= DW'(cur_n);
                            div_go <= 1'b1;
                            state  <= ST_FREQ;
                        end else begin
                            state <= ST_NEXT;
                        end
                    end
                end
                ST_FREQ: begin
                    if (div_done) begin
                        if (f_ok && (delta_c < best_delta)) begin
                            best_delta <= delta_c;
                            best_n     <= cur_n;
                            best_m     <= cur_m;
                            best_f     <= div_q[31:0];
                            found      <= 1'b1;
                        end
                        state <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (cur_n >= NW'(NMAX)) begin
                        if (found) begin
                            div_a  <= DW'(best_f) + MEG_D - DW'(1);
                            div_b  <= MEG_D;
                            div_go <= 1'b1;
                            state  <= ST_MBPS;
                        end else begin
                            err          <= 1'b1;
                            n_div        <= '0;
                            m_mult       <= '0;
                            lane_rate_hz <= '0;
                            range_idx    <= '0;
                            state        <= ST_FIN;
                        end
                    end else begin
                        cur_n  <= n_inc;
                        div_a  <= tgt * DW'(n_inc);
                        div_b  <= FREF_D;
                        div_go <= 1'b1;
                        state  <= ST_MCAND;
                    end
                end
                ST_MBPS: begin
                    if (div_done) begin
                        err          <= 1'b0;
                        n_div        <= best_n;
                        m_mult       <= best_m;
                        lane_rate_hz <= best_f;
                        range_idx    <= idx_c;
                        state        <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lane_pll_search_chk.sv
// Property checker for lane_pll_search, attached through bind.
// Assumes the parameters match those of the bound instance.
module lane_pll_search_chk #(
    parameter int NMIN = 1,
    parameter int NMAX = 4,
    parameter int NW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [NW-1:0] n_div,
    input logic [9:0]    m_mult,
    input logic [31:0]   lane_rate_hz,
    input logic [5:0]    range_idx
);
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(n_div) && $stable(m_mult) &&
                               $stable(lane_rate_hz) && $stable(err)));
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    p_n_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (n_div >= NW'(NMIN) && n_div <= NW'(NMAX)));
    p_m_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (!m_mult[0] && m_mult >= 10'd6 && m_mult <= 10'd512));
    p_rate_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (lane_rate_hz >= 32'd80_000_000 &&
                            lane_rate_hz <= 32'd1_500_000_000));
    p_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (range_idx <= 6'd38));
endmodule

bind lane_pll_search lane_pll_search_chk #(
    .NMIN (NMIN),
    .NMAX (NMAX),
    .NW   (NW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .n_div        (n_div),
    .m_mult       (m_mult),
    .lane_rate_hz (lane_rate_hz),
    .range_idx    (range_idx)
);

// File: tb/test_lane_pll_search.sv
module test_lane_pll_search;
    localparam longint FREF = 24_000_000;
    localparam int     NW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [19:0]   pclk_khz = '0;
    logic [2:0]    lane_cnt = 3'd1;
    logic [1:0]    pix_fmt = '0;
    logic          busy, done, err;
    logic [NW-1:0] n_div;
    logic [9:0]    m_mult;
    logic [31:0]   lane_rate_hz;
    logic [5:0]    range_idx;

    int checks = 0;
    int fails = 0;
    longint cycles = 0;

    always #4 clk = ~clk;

    lane_pll_search i_lane_pll_search (
        .clk(clk), .rst_n(rst_n), .start(start), .pclk_khz(pclk_khz),
        .lane_cnt(lane_cnt), .pix_fmt(pix_fmt), .busy(busy), .done(done),
        .err(err), .n_div(n_div), .m_mult(m_mult),
        .lane_rate_hz(lane_rate_hz), .range_idx(range_idx)
    );

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            summary_and_end();
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic longint bpp_ref(input int f);
        if (f == 2) return 18;
        if (f == 3) return 16;
        return 24;
    endfunction

    function automatic int band_ref(input longint mbps);
        int tops[39] = '{89,99,109,129,139,149,169,179,199,219,239,249,269,299,
                         329,359,399,449,499,549,599,649,699,749,799,849,899,
                         949,999,1049,1099,1149,1199,1249,1299,1349,1399,1449,1500};
        for (int i = 0; i < 39; i++) if (tops[i] >= mbps) return i;
        return 38;
    endfunction

    // Model per R2..R8: returns err and the chosen values.
    task automatic model(input longint khz, input longint ln, input int f,
                         output bit e, output longint bn, output longint bm,
                         output longint bf, output int bi);
        longint t, best, m, fq, d;
        bit got;
        t = (khz * 1000) / ln * bpp_ref(f) / 8 * 10;
        e = 1; bn = 0; bm = 0; bf = 0; bi = 0;
        if (t >= 1_500_000_000) return;
        best = 1_500_000_000; got = 0;
        for (longint n = 1; n <= 4; n++) begin
            m = t * n / FREF;
            m = m + (m % 2);
            if (m < 6 || m > 512) continue;
            fq = m * FREF / n;
            if (fq < 80_000_000 || fq > 1_500_000_000) continue;
            d = (t > fq) ? t - fq : fq - t;
            if (d >= best) continue;
            best = d; bn = n; bm = m; bf = fq; got = 1;
        end
        if (!got) return;
        e = 0;
        bi = band_ref((bf + 999_999) / 1_000_000);
    endtask

    // Issue one request; optional extra start during busy (R10) and at done.
    task automatic run_case(input longint khz, input int ln, input int f,
                            input bit disturb, input string tag);
        bit e; longint en, em, ef; int ei; int w;
        model(khz, ln, f, e, en, em, ef, ei);
        @(negedge clk);
        pclk_khz = 20'(khz); lane_cnt = 3'(ln); pix_fmt = 2'(f); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (20) @(negedge clk);
            pclk_khz = 20'd33333; lane_cnt = 3'd2; pix_fmt = 2'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 2000) begin @(negedge clk); w++; end
        if (disturb) begin
            pclk_khz = 20'd55555; lane_cnt = 3'd1; pix_fmt = 2'd2; start = 1'b1;
        end
        chk({tag, " R9 done seen"}, done, 1);
        chk({tag, " R2 R7 err"}, err, e);
        if (!e) begin
            chk({tag, " R3 R6 n"}, n_div, en);
            chk({tag, " R4 m"}, m_mult, em);
            chk({tag, " R5 rate"}, lane_rate_hz, ef);
            chk({tag, " R8 band"}, range_idx, ei);
        end
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // the start in the done cycle was dropped: no new run begins
            chk({tag, " R10 busy after done"}, busy, 0);
            chk({tag, " R10 n kept"}, n_div, e ? 0 : en);
        end
        chk({tag, " R9 done single"}, done, 0);
        repeat (3) @(negedge clk);
        chk({tag, " R9 hold rate"}, lane_rate_hz, e ? 0 : ef);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 err", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: each format code
        for (int f = 0; f < 4; f++) run_case(148500, 4, f, 0, "R1 fmt");
        // R2 boundary around the 1500 Mbps limit
        run_case(74999, 1, 3, 0, "R2 below");
        run_case(75000, 1, 3, 0, "R2 at");
        run_case(1000000, 1, 0, 0, "R2 far");
        // R7: target too low for any legal M
        run_case(1000, 4, 3, 0, "R7 low");
        run_case(5000, 2, 2, 0, "R7 edge");
        // R10: extra starts while busy and in the done cycle
        run_case(148500, 4, 0, 1, "R10 busy");
        run_case(65000, 2, 1, 1, "R10 busy2");
        // R6 R8: random mix
        for (int i = 0; i < 40; i++) begin
            longint k; int l; int f;
            k = 10000 + longint'($urandom_range(0, 290000));
            l = int'($urandom_range(1, 4));
            f = int'($urandom_range(0, 3));
            run_case(k, l, f, 0, "R6 rand");
        end
        summary_and_end();
    end
endmodule